// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block extends a parallel port register set with enhanced-parallel-port (EPP) address and data cycles. A host issues single-cycle requests that carry a write flag, a register offset and an access size. Offset 3 starts an address cycle and offset 4 starts a data cycle. Data cycles may be 8, 16 or 32 bits wide, and wide accesses are split into bytes that go out least significant byte first. Each EPP cycle is forwarded to the peripheral only when the control register holds the exact bit pattern for the direction asked for. Any other pattern makes the access complete at once, with no peripheral activity.

On the peripheral side every byte runs a four-phase handshake. The block raises the data strobe, or the address strobe for offset 3, and waits for the peripheral's wait line to rise. It then drops the strobe and waits for the wait line to fall. If either phase gets no answer within a parameterised number of cycles, the access is abandoned, the bytes not yet sent are skipped, and a sticky timeout flag is set. Software sees the flag in bit 0 of the status register and clears it by writing a 1 to that bit. The host is told busy until the whole access has completed or been abandoned.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset the timeout flag is 0, the control register reads 0xCC, both strobes are low, hostBusy is low and no byte is driven.
- R2: An EPP write (offset 3 or 4) starts a peripheral cycle only when (control AND 0x2F) equals 0x04. Otherwise it completes on the next cycle with no strobe.
- R3: An EPP read starts a peripheral cycle only when (control AND 0x2F) equals 0x24. Otherwise it completes on the next cycle and returns all ones at the access width, with the upper bits zero: size 0 gives 0xFF, size 1 gives 0xFFFF, size 2 or 3 gives 0xFFFFFFFF, and offset 3 always gives 0xFF.
- R4: Each byte raises dataStrobe (offset 4) or addrStrobe (offset 3), never both, and holds it until periphWait is high. The strobe then stays low until periphWait is low. During writes writeCycle is high and periphDataOut holds steady while a strobe is high.
- R5: Size 1 moves 2 bytes and sizes 2 and 3 move 4 bytes, least significant byte first for writes. Read bytes are placed from bit 0 upward in the order they are received. Offset 3 always moves one byte.
- R6: If periphWait does not answer within TIMEOUT_CYCLES cycles in either phase, the access stops, no later byte is attempted and the timeout flag is set. A read returns 0xFF in every byte lane that was not received.
- R7: A status read (offset 1) returns periphStatus bits 7..1 with the timeout flag in bit 0.
- R8: A status write with bit 0 = 1 clears the timeout flag. With bit 0 = 0 the flag is unchanged.
- R9: hostBusy is high from the cycle after an EPP cycle is accepted until the cycle in which hostDone pulses. Requests made while busy are ignored.
- R10: With hostEcp = 1 writes change nothing and reads return 0xFF. Reads of offsets 0, 5, 6 and 7 also return 0xFF.
- R11: A control write (offset 2) stores the written byte with bits 7 and 6 forced to 1. It reads back on offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, sampled while hostBusy is low |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostEcp | input | 1 | Selects the extended-capability window |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | 0 = byte, 1 = 16 bits, 2/3 = 32 bits |
| hostWdata | input | DATA_W | Write data |
| hostRdata | output | DATA_W | Read data, valid while hostDone is high |
| hostBusy | output | 1 | A peripheral transfer is in progress |
| hostDone | output | 1 | One-cycle completion pulse |
| periphStatus | input | 8 | Raw peripheral status lines |
| periphWait | input | 1 | Peripheral handshake response |
| periphDataIn | input | 8 | Byte driven by the peripheral on reads |
| periphDataOut | output | 8 | Byte driven toward the peripheral |
| writeCycle | output | 1 | Write direction; the block drives periphDataOut |
| dataStrobe | output | 1 | Data cycle strobe |
| addrStrobe | output | 1 | Address cycle strobe |

## Verification
The assertions check the following on every cycle:
- the two strobes are never high together;
- a strobe is only ever high while hostBusy is high;
- the outgoing byte does not change while a strobe is high;
- hostDone never pulses while busy;
- a request refused by the control gate completes on the next cycle without starting a transfer;
- the flag rises only during a transfer;
- a status clear takes effect;
- writes to the extended window leave the state alone.

Other behaviour can only be shown by the bench's scenarios:
- the byte order on the peripheral side and the values read back;
- the exact cycle at which a slow response turns into a timeout;
- the 0xFF filling of lanes lost to an abort;
- a full sweep of control values through both gates.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;

  localparam logic [2:0] OFF_STATUS   = 3'd1;
  localparam logic [2:0] OFF_CONTROL  = 3'd2;
  localparam logic [2:0] OFF_EPP_ADDR = 3'd3;
  localparam logic [2:0] OFF_EPP_DATA = 3'd4;

  localparam logic [7:0] CTL_RESET   = 8'hCC;
  localparam logic [7:0] CTL_FORCED  = 8'hC0;
  localparam logic [7:0] GATE_MASK   = 8'h2F;
  localparam logic [7:0] GATE_WRITE  = 8'h04;
  localparam logic [7:0] GATE_READ   = 8'h24;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RELEASE = 2'd2
  } phaseT;

  typedef struct packed {
    logic ctlWrite;
    logic flagClear;
    logic flagSet;
    logic loadXfer;
    logic shiftNext;
    logic captureByte;
    logic latchReg;
    logic latchXfer;
  } dpStrobeT;

  function automatic int unsigned xferBytes(input logic [2:0] addr, input logic [1:0] size);
    if (addr == OFF_EPP_ADDR) return 1;
    case (size)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/epp_gate_datapath.sv
module epp_gate_datapath
  import epp_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          dp,
  input  logic              hostEcp,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [7:0]        periphStatus,
  input  logic [7:0]        periphDataIn,
  input  logic [IDX_W-1:0]  byteIdx,
  output logic [7:0]        ctlValue,
  output logic              timeoutFlag,
  output logic              gateWr,
  output logic              gateRd,
  output logic [DATA_W-1:0] hostRdata,
  output logic [7:0]        periphDataOut
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] readAcc;
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] regRead;

  always_comb begin
    int unsigned nb;
    nb = xferBytes(hostAddr, hostSize);
    for (int i = 0; i < LANES; i++) begin
      widthMask[i*8 +: 8] = (i < nb) ? 8'hFF : 8'h00;
    end
  end

  always_comb begin
    regRead = DATA_W'(8'hFF);
    if (!hostEcp) begin
      case (hostAddr)
        OFF_STATUS:   regRead = DATA_W'({periphStatus[7:1], timeoutFlag});
        OFF_CONTROL:  regRead = DATA_W'(ctlValue);
        OFF_EPP_ADDR,
        OFF_EPP_DATA: regRead = widthMask;
        default:      regRead = DATA_W'(8'hFF);
      endcase
    end
  end

  assign gateWr        = (ctlValue & GATE_MASK) == GATE_WRITE;
  assign gateRd        = (ctlValue & GATE_MASK) == GATE_READ;
  assign periphDataOut = shiftReg[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlValue    <= CTL_RESET;
      timeoutFlag <= 1'b0;
    end else begin
      if (dp.ctlWrite) ctlValue <= hostWdata[7:0] | CTL_FORCED;
      if (dp.flagSet) timeoutFlag <= 1'b1;
      else if (dp.flagClear) timeoutFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (dp.loadXfer) begin
      shiftReg <= hostWdata;
    end else if (dp.shiftNext) begin
      shiftReg <= shiftReg >> 8;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          readAcc[g*8 +: 8] <= 8'h00;
        end else if (dp.loadXfer) begin
          readAcc[g*8 +: 8] <= widthMask[g*8 +: 8];
        end else if (dp.captureByte && (byteIdx == IDX_W'(g))) begin
          readAcc[g*8 +: 8] <= periphDataIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (dp.latchReg) begin
      hostRdata <= regRead;
    end else if (dp.latchXfer) begin
      hostRdata <= readAcc;
    end
  end

endmodule

// File: rtl/epp_gate_control.sv
module epp_gate_control
  import epp_gate_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int LANES          = 4,
  parameter int IDX_W          = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWrite,
  input  logic             hostEcp,
  input  logic [2:0]       hostAddr,
  input  logic [1:0]       hostSize,
  input  logic             clearBit,
  input  logic             gateWr,
  input  logic             gateRd,
  input  logic             periphWait,
  output dpStrobeT         dp,
  output logic [IDX_W-1:0] byteIdx,
  output logic             hostBusy,
  output logic             hostDone,
  output logic             writeCycle,
  output logic             dataStrobe,
  output logic             addrStrobe
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  phaseT            phase, phaseNext;
  logic [CNT_W-1:0] waitCnt;
  logic [IDX_W-1:0] lastIdx, lastCalc;
  logic             xferWrite, xferAddr;
  logic             accept, eppOffset, launch, cntExpired, finish;

  always_comb begin
    int unsigned nb;
    nb = xferBytes(hostAddr, hostSize);
    if (nb > LANES) nb = LANES;
    lastCalc   = IDX_W'(nb - 1);
    accept     = hostReq && (phase == ST_IDLE);
    eppOffset  = !hostEcp && ((hostAddr == OFF_EPP_ADDR) || (hostAddr == OFF_EPP_DATA));
    launch     = eppOffset && (hostWrite ? gateWr : gateRd);
    cntExpired = (waitCnt == CNT_W'(TIMEOUT_CYCLES - 1));
  end

  always_comb begin
    dp        = '0;
    phaseNext = phase;
    finish    = 1'b0;
    case (phase)
      ST_IDLE: begin
        if (accept) begin
          if (launch) begin
            dp.loadXfer = 1'b1;
            phaseNext   = ST_STROBE;
          end else begin
            dp.latchReg  = 1'b1;
            finish       = 1'b1;
            dp.ctlWrite  = hostWrite && !hostEcp && (hostAddr == OFF_CONTROL);
            dp.flagClear = hostWrite && !hostEcp && (hostAddr == OFF_STATUS) && clearBit;
          end
        end
      end
      ST_STROBE: begin
        if (periphWait) begin
          dp.captureByte = !xferWrite;
          phaseNext      = ST_RELEASE;
        end else if (cntExpired) begin
          dp.flagSet   = 1'b1;
          dp.latchXfer = 1'b1;
          finish       = 1'b1;
          phaseNext    = ST_IDLE;
        end
      end
      ST_RELEASE: begin
        if (!periphWait) begin
          if (byteIdx == lastIdx) begin
            dp.latchXfer = 1'b1;
            finish       = 1'b1;
            phaseNext    = ST_IDLE;
          end else begin
            dp.shiftNext = 1'b1;
            phaseNext    = ST_STROBE;
          end
        end else if (cntExpired) begin
          dp.flagSet   = 1'b1;
          dp.latchXfer = 1'b1;
          finish       = 1'b1;
          phaseNext    = ST_IDLE;
        end
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      waitCnt   <= '0;
      byteIdx   <= '0;
      lastIdx   <= '0;
      xferWrite <= 1'b0;
      xferAddr  <= 1'b0;
      hostDone  <= 1'b0;
    end else begin
      phase    <= phaseNext;
      hostDone <= finish;
      if (dp.loadXfer) begin
        byteIdx   <= '0;
        lastIdx   <= lastCalc;
        xferWrite <= hostWrite;
        xferAddr  <= (hostAddr == OFF_EPP_ADDR);
      end else if (dp.shiftNext) begin
        byteIdx <= byteIdx + 1'b1;
      end
      if (phaseNext != phase) waitCnt <= '0;
      else if (phase != ST_IDLE) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign hostBusy   = (phase != ST_IDLE);
  assign writeCycle = hostBusy && xferWrite;
  assign dataStrobe = (phase == ST_STROBE) && !xferAddr;
  assign addrStrobe = (phase == ST_STROBE) && xferAddr;

endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostEcp,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostBusy,
  output logic              hostDone,
  input  logic [7:0]        periphStatus,
  input  logic              periphWait,
  input  logic [7:0]        periphDataIn,
  output logic [7:0]        periphDataOut,
  output logic              writeCycle,
  output logic              dataStrobe,
  output logic              addrStrobe
);

  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  dpStrobeT         dpCtl;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       ctlValue;
  logic             timeoutFlag;
  logic             gateWr, gateRd;

  epp_gate_control #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .LANES         (LANES),
    .IDX_W         (IDX_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .hostEcp   (hostEcp),
    .hostAddr  (hostAddr),
    .hostSize  (hostSize),
    .clearBit  (hostWdata[0]),
    .gateWr    (gateWr),
    .gateRd    (gateRd),
    .periphWait(periphWait),
    .dp        (dpCtl),
    .byteIdx   (byteIdx),
    .hostBusy  (hostBusy),
    .hostDone  (hostDone),
    .writeCycle(writeCycle),
    .dataStrobe(dataStrobe),
    .addrStrobe(addrStrobe)
  );

  epp_gate_datapath #(
    .DATA_W(DATA_W),
    .LANES (LANES),
    .IDX_W (IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .dp           (dpCtl),
    .hostEcp      (hostEcp),
    .hostAddr     (hostAddr),
    .hostSize     (hostSize),
    .hostWdata    (hostWdata),
    .periphStatus (periphStatus),
    .periphDataIn (periphDataIn),
    .byteIdx      (byteIdx),
    .ctlValue     (ctlValue),
    .timeoutFlag  (timeoutFlag),
    .gateWr       (gateWr),
    .gateRd       (gateRd),
    .hostRdata    (hostRdata),
    .periphDataOut(periphDataOut)
  );

endmodule

// File: rtl/epp_cycle_gate_checker.sv
module epp_cycle_gate_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReq,
  input logic              hostWrite,
  input logic              hostEcp,
  input logic [2:0]        hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              hostBusy,
  input logic              hostDone,
  input logic              dataStrobe,
  input logic              addrStrobe,
  input logic [7:0]        periphDataOut,
  input logic [7:0]        ctlValue,
  input logic              timeoutFlag
);

  logic idleReq, eppAddr;
  assign idleReq = hostReq && !hostBusy;
  assign eppAddr = !hostEcp && ((hostAddr == 3'd3) || (hostAddr == 3'd4));

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(dataStrobe && addrStrobe)); // R4

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe || addrStrobe) && $past(dataStrobe || addrStrobe) |-> $stable(periphDataOut)); // R4

  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe || addrStrobe) |-> hostBusy); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |-> !hostBusy); // R9

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && hostWrite && eppAddr && ((ctlValue & 8'h2F) != 8'h04) |=> !hostBusy && hostDone); // R2

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && !hostWrite && eppAddr && ((ctlValue & 8'h2F) != 8'h24) |=> !hostBusy && hostDone); // R3

  AST_FLAG_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(hostBusy)); // R6

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && hostWrite && !hostEcp && (hostAddr == 3'd1) && hostWdata[0] |=> !timeoutFlag); // R8

  AST_ECP_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && hostWrite && hostEcp |=> $stable(ctlValue) && $stable(timeoutFlag)); // R10

endmodule

bind epp_cycle_gate epp_cycle_gate_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostReq      (hostReq),
  .hostWrite    (hostWrite),
  .hostEcp      (hostEcp),
  .hostAddr     (hostAddr),
  .hostWdata    (hostWdata),
  .hostBusy     (hostBusy),
  .hostDone     (hostDone),
  .dataStrobe   (dataStrobe),
  .addrStrobe   (addrStrobe),
  .periphDataOut(periphDataOut),
  .ctlValue     (ctlValue),
  .timeoutFlag  (timeoutFlag)
);

// File: tb/epp_cycle_gate_bench.sv
module epp_cycle_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 12;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostReq = 1'b0, hostWrite = 1'b0, hostEcp = 1'b0;
  logic [2:0]        hostAddr = '0;
  logic [1:0]        hostSize = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic [DATA_W-1:0] hostRdata;
  logic              hostBusy, hostDone;
  logic [7:0]        periphStatus = 8'h00;
  logic              periphWait = 1'b0;
  logic [7:0]        periphDataIn = 8'h30;
  logic [7:0]        periphDataOut;
  logic              writeCycle, dataStrobe, addrStrobe;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // peripheral model controls (driven by the initial block only)
  int respDelay = 0, respLimit = 1000;
  bit holdWait = 0, clrReq = 0;
  // peripheral model state (driven by the model only)
  int dcnt = 0, hsDone = 0, rdIdx = 0, strobeRises = 0, logCount = 0;
  bit prevStb = 0;
  logic [7:0] logData [0:15];
  bit         logAddr [0:15];

  epp_cycle_gate #(.DATA_W(DATA_W), .TIMEOUT_CYCLES(TMO)) u_epp_cycle_gate (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite), .hostEcp(hostEcp),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostBusy(hostBusy), .hostDone(hostDone), .periphStatus(periphStatus),
    .periphWait(periphWait), .periphDataIn(periphDataIn), .periphDataOut(periphDataOut),
    .writeCycle(writeCycle), .dataStrobe(dataStrobe), .addrStrobe(addrStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    bit stb;
    stb = dataStrobe | addrStrobe;
    if (clrReq) begin
      dcnt = 0; hsDone = 0; rdIdx = 0; strobeRises = 0; logCount = 0;
      prevStb = 0; periphWait = 1'b0; periphDataIn = 8'h30;
    end else begin
      if (stb && !prevStb) strobeRises++;
      prevStb = stb;
      if (stb && !periphWait) begin
        if (hsDone < respLimit) begin
          if (dcnt >= respDelay) begin
            periphWait = 1'b1; dcnt = 0; hsDone++;
            if (writeCycle && logCount < 16) begin
              logData[logCount] = periphDataOut;
              logAddr[logCount] = addrStrobe;
              logCount++;
            end
          end else dcnt++;
        end
      end else if (!stb && periphWait) begin
        if (!holdWait) begin
          if (dcnt >= respDelay) begin
            periphWait = 1'b0; dcnt = 0; rdIdx++;
            periphDataIn = 8'h30 + 8'(rdIdx);
          end else dcnt++;
        end
      end else dcnt = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clearPeriph();
    clrReq = 1;
    @(negedge clk);
    #1 clrReq = 0;
  endtask

  task automatic access(input bit ecp, input logic [2:0] addr, input logic [1:0] size,
                        input bit wr, input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    hostReq = 1; hostEcp = ecp; hostAddr = addr; hostSize = size; hostWrite = wr; hostWdata = wd;
    @(negedge clk);
    hostReq = 0;
    n = 0;
    while (!hostDone && n < TMO * 20) begin
      @(negedge clk);
      n++;
    end
    if (!hostDone) check("R9 done missing", 32'd0, 32'd1);
    rd = hostRdata;
  endtask

  task automatic readStatus(output logic [31:0] rd);
    access(0, 3'd1, 2'd0, 0, 32'd0, rd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    periphStatus = 8'hA5;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, hostBusy}, 32'd0);
    check("R1 strobes", {30'd0, dataStrobe, addrStrobe}, 32'd0);
    check("R1 writeCycle", {31'd0, writeCycle}, 32'd0);
    readStatus(rd); check("R1 R7 status after reset", rd, 32'hA4);
    access(0, 3'd2, 2'd0, 0, 0, rd); check("R1 control after reset", rd, 32'hCC);

    // R11 control write with forced bits
    access(0, 3'd2, 2'd0, 1, 32'h15, rd);
    access(0, 3'd2, 2'd0, 0, 0, rd); check("R11 control readback", rd, 32'hD5);

    // R2 / R3 sweep of every control value
    for (int v = 0; v < 256; v++) begin
      bit wrOk, rdOk;
      logic [2:0] a;
      wrOk = ((v & 8'h2F) == 8'h04);
      rdOk = ((v & 8'h2F) == 8'h24);
      a = v[6] ? 3'd3 : 3'd4;
      access(0, 3'd2, 2'd0, 1, 32'(v), rd);
      clearPeriph();
      access(0, a, 2'd0, 1, 32'h5A, rd);
      check("R2 write gate bytes", 32'(logCount), wrOk ? 32'd1 : 32'd0);
      if (wrOk && logCount == 1) begin
        check("R2 write byte", {24'd0, logData[0]}, 32'h5A);
        check("R4 strobe kind", {31'd0, logAddr[0]}, {31'd0, (a == 3'd3)});
      end
      clearPeriph();
      access(0, a, 2'd0, 0, 32'd0, rd);
      check("R3 read gate value", rd, rdOk ? 32'h30 : 32'hFF);
    end

    // R3 gated-off reads return ones at width
    access(0, 3'd2, 2'd0, 1, 32'h00, rd);
    clearPeriph();
    access(0, 3'd4, 2'd0, 0, 0, rd); check("R3 width 8", rd, 32'h000000FF);
    access(0, 3'd4, 2'd1, 0, 0, rd); check("R3 width 16", rd, 32'h0000FFFF);
    access(0, 3'd4, 2'd2, 0, 0, rd); check("R3 width 32", rd, 32'hFFFFFFFF);
    access(0, 3'd4, 2'd3, 0, 0, rd); check("R3 width 32 size3", rd, 32'hFFFFFFFF);
    access(0, 3'd3, 2'd2, 0, 0, rd); check("R3 addr cycle width", rd, 32'h000000FF);
    check("R3 no strobe", 32'(strobeRises), 32'd0);

    // R5 byte order for writes
    access(0, 3'd2, 2'd0, 1, 32'h04, rd);
    clearPeriph();
    access(0, 3'd4, 2'd2, 1, 32'h11223344, rd);
    check("R5 32-bit count", 32'(logCount), 32'd4);
    for (int i = 0; i < 4; i++)
      check("R5 32-bit lane", {24'd0, logData[i]}, 32'(8'h44 - 8'(i) * 8'h11));
    clearPeriph();
    access(0, 3'd4, 2'd1, 1, 32'hAABBCCDD, rd);
    check("R5 16-bit count", 32'(logCount), 32'd2);
    check("R5 16-bit lane0", {24'd0, logData[0]}, 32'hDD);
    check("R5 16-bit lane1", {24'd0, logData[1]}, 32'hCC);
    clearPeriph();
    access(0, 3'd3, 2'd2, 1, 32'h99887766, rd);
    check("R5 addr cycle one byte", 32'(logCount), 32'd1);
    check("R4 addr strobe used", {31'd0, logAddr[0]}, 32'd1);
    check("R5 addr byte", {24'd0, logData[0]}, 32'h66);

    // R4 response delay sweep up to the limit, with success
    for (int d = 0; d < TMO; d++) begin
      respDelay = d;
      clearPeriph();
      access(0, 3'd4, 2'd1, 1, 32'h0000BEEF, rd);
      check("R4 delayed handshake bytes", 32'(logCount), 32'd2);
      readStatus(rd);
      check("R6 no timeout within limit", rd & 32'h1, 32'd0);
    end

    // R5 read assembly
    respDelay = 1;
    access(0, 3'd2, 2'd0, 1, 32'h24, rd);
    clearPeriph();
    access(0, 3'd4, 2'd2, 0, 0, rd); check("R5 32-bit read", rd, 32'h33323130);
    clearPeriph();
    access(0, 3'd4, 2'd1, 0, 0, rd); check("R5 16-bit read", rd, 32'h00003130);

    // R6 timeout one cycle past the limit
    respDelay = TMO;
    access(0, 3'd2, 2'd0, 1, 32'h04, rd);
    clearPeriph();
    access(0, 3'd4, 2'd0, 1, 32'h12, rd);
    check("R6 no byte sent", 32'(logCount), 32'd0);
    periphStatus = 8'h00;
    readStatus(rd); check("R6 R7 flag in status", rd, 32'h01);
    periphStatus = 8'hFF;
    access(0, 3'd1, 2'd0, 1, 32'hFE, rd);
    readStatus(rd); check("R8 bit0 zero keeps flag", rd, 32'hFF);
    access(0, 3'd1, 2'd0, 1, 32'h01, rd);
    readStatus(rd); check("R8 clear flag", rd, 32'hFE);

    // R6 partial write stops after the stalled byte
    respDelay = 0; respLimit = 2;
    clearPeriph();
    access(0, 3'd4, 2'd2, 1, 32'hCAFEF00D, rd);
    check("R6 bytes completed", 32'(logCount), 32'd2);
    check("R6 strobes attempted", 32'(strobeRises), 32'd3);
    readStatus(rd); check("R6 flag after partial", rd & 32'h1, 32'd1);
    access(0, 3'd1, 2'd0, 1, 32'h01, rd);

    // R6 partial read fills lost lanes with ones
    respLimit = 1;
    access(0, 3'd2, 2'd0, 1, 32'h24, rd);
    clearPeriph();
    access(0, 3'd4, 2'd2, 0, 0, rd); check("R6 partial read lanes", rd, 32'hFFFFFF30);
    access(0, 3'd1, 2'd0, 1, 32'h01, rd);

    // R6 stall in the release phase
    respLimit = 1000; holdWait = 1;
    access(0, 3'd2, 2'd0, 1, 32'h04, rd);
    clearPeriph();
    access(0, 3'd4, 2'd1, 1, 32'h00004321, rd);
    check("R6 release stall bytes", 32'(logCount), 32'd1);
    readStatus(rd); check("R6 release stall flag", rd & 32'h1, 32'd1);
    holdWait = 0;
    clearPeriph();
    access(0, 3'd1, 2'd0, 1, 32'h01, rd);

    // R9 request during busy is ignored
    respDelay = 3;
    clearPeriph();
    @(negedge clk);
    hostReq = 1; hostEcp = 0; hostAddr = 3'd4; hostSize = 2'd0; hostWrite = 1; hostWdata = 32'h77;
    @(negedge clk);
    check("R9 busy after accept", {31'd0, hostBusy}, 32'd1);
    hostAddr = 3'd2; hostWdata = 32'h00;
    @(negedge clk);
    hostReq = 0;
    for (int n = 0; n < TMO * 20 && !hostDone; n++) @(negedge clk);
    check("R9 done seen", {31'd0, hostDone}, 32'd1);
    check("R9 byte sent", {24'd0, logData[0]}, 32'h77);
    access(0, 3'd2, 2'd0, 0, 0, rd); check("R9 control untouched", rd, 32'hC4);

    // R10 extended window and undecoded offsets
    access(1, 3'd2, 2'd0, 1, 32'h00, rd);
    access(0, 3'd2, 2'd0, 0, 0, rd); check("R10 ecp write ignored", rd, 32'hC4);
    access(1, 3'd1, 2'd0, 0, 0, rd); check("R10 ecp read", rd, 32'hFF);
    access(0, 3'd0, 2'd0, 0, 0, rd); check("R10 offset 0 read", rd, 32'hFF);
    access(0, 3'd5, 2'd0, 0, 0, rd); check("R10 offset 5 read", rd, 32'hFF);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule